// File: doc/BRIEF.md
# Video Pixel Output Formatter

This block sits at the end of a video pipeline. It takes one full-precision pixel per clock (three 12-bit components: luma or green, then blue-difference, then red-difference chroma) together with horizontal sync, vertical sync, field and data-enable. It packs that pixel onto an output bus in one of four formats: single-rate 4:4:4, single-rate 4:2:2, double-rate 4:2:2 and double-rate 4:4:4. The output pads that drive both clock edges are not part of this block. Double-rate output is therefore given as two words: one for the rising edge and one for the falling edge.

A format code and a depth code select the packing. The depth code chooses 8, 10 or 12 bits per component. The timing outputs pass through the same two-register pipeline as the data, so they stay aligned with it in every format. Each timing output has its own polarity control. The vertical output can carry either vertical sync or the field flag.

Top module: `vfmt_top`

## Requirements
- R1: While reset is asserted, and right after it, rise_o, fall_o, hs_o, vsf_o and de_o are all zero, whatever the inputs and polarity controls are.
- R2: Data and timing reach the outputs exactly two clocks after they are presented, in every format. A single-cycle de_i pulse gives a single-cycle de_o pulse two clocks later and nothing one clock later.
- R3: Format code 0 (single-rate 4:4:4) puts {Y, Cb, Cr} in rise_o[3W-1:0], with Y in the top slot. W is 8, 10 or 12 for depth code 0, 1 or 2, and depth code 3 acts as 12. Bits above 3W are zero and fall_o is zero.
- R4: Format code 1 (single-rate 4:2:2) puts {Y, C} in rise_o[2W-1:0], with Y in the upper slot. All other bits and fall_o are zero.
- R5: In the 4:2:2 formats, C is Cb on even pixels and Cr on odd pixels. The first pixel after each rising edge of de_i is even, and the phase alternates on every pixel with de_i high.
- R6: Format code 2 (double-rate 4:2:2) puts C in rise_o[W-1:0] and Y in fall_o[W-1:0]. All higher bits are zero.
- R7: Format code 3 (double-rate 4:4:4) ignores depth_i. rise_o[17:0] = pix_i[35:18], fall_o[17:0] = pix_i[17:0], and higher bits are zero.
- R8: When hs_pol_i, vs_pol_i or de_pol_i is 1, the matching output hs_o, vsf_o or de_o is inverted. When it is 0, the output is not inverted.
- R9: vsf_o carries field_i when vsel_field_i is 1 and vs_i when it is 0.
- R10: A reduced depth W keeps the upper W bits of each 12-bit component and drops the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 2 | Format: 0 SDR 4:4:4, 1 SDR 4:2:2, 2 DDR 4:2:2, 3 DDR 4:4:4 |
| depth_i | input | 2 | Component depth: 0 8-bit, 1 10-bit, 2 or 3 12-bit |
| pix_i | input | 36 | Pixel {Y, Cb, Cr}, Y in bits 35:24, Cr in bits 11:0 |
| hs_i | input | 1 | Horizontal sync, active high |
| vs_i | input | 1 | Vertical sync, active high |
| field_i | input | 1 | Field flag |
| de_i | input | 1 | Active-pixel enable |
| hs_pol_i | input | 1 | Invert hs_o |
| vs_pol_i | input | 1 | Invert vsf_o |
| de_pol_i | input | 1 | Invert de_o |
| vsel_field_i | input | 1 | 1 puts field on vsf_o, 0 puts vertical sync |
| rise_o | output | 36 | Bus word (the only word in single-rate formats) |
| fall_o | output | 36 | Falling-edge word in double-rate formats, zero otherwise |
| hs_o | output | 1 | Horizontal sync out |
| vsf_o | output | 1 | Vertical sync or field out |
| de_o | output | 1 | Data enable out |

## Verification
The packing is tried with one fixed pixel whose three components all have different bit patterns. It runs through every format and depth, with an even and an odd pixel each time. This shows whether a slot order is swapped, whether Cb and Cr are confused, and whether truncation keeps the high bits or the low bits. A single-pixel burst followed by a new burst tells a phase that restarts on the enable edge from one that just carries on. A three-pixel burst shows that the phase alternates. Single-cycle enable pulses, polarity settings and vertical-output selections show the two-clock alignment and that each timing control acts alone.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

  typedef enum logic [1:0] {
    FMT_SDR_444 = 2'd0,
    FMT_SDR_422 = 2'd1,
    FMT_DDR_422 = 2'd2,
    FMT_DDR_444 = 2'd3
  } fmt_e;

  // Bits kept per component for a depth code, capped at the component width.
  function automatic int unsigned depth_bits(input logic [1:0] code, input int unsigned comp_w);
    int unsigned b;
    b = 8 + 2 * int'(code);
    if (b > comp_w) b = comp_w;
    return b;
  endfunction

endpackage

// File: rtl/vfmt_phase.sv
module vfmt_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic de_i,
  output logic de_rise_o,
  output logic odd_o
);
  logic de_q;
  logic ph_q;

  assign de_rise_o = de_i & ~de_q;
  assign odd_o     = de_rise_o ? 1'b0 : ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q <= 1'b0;
      ph_q <= 1'b0;
    end else begin
      de_q <= de_i;
      if (de_i) ph_q <= ~odd_o;
    end
  end
endmodule

// File: rtl/vfmt_pack.sv
module vfmt_pack #(
  parameter int COMP_W = 12
) (
  input  vfmt_pkg::fmt_e                fmt,
  input  logic [1:0]                    depth,
  input  logic                          odd,
  input  logic [3*COMP_W-1:0]           pix,
  output logic [3*COMP_W-1:0]           rise,
  output logic [3*COMP_W-1:0]           fall
);
  import vfmt_pkg::*;

  localparam int NCOMP  = 3;
  localparam int PIX_W  = NCOMP * COMP_W;
  localparam int HALF_W = PIX_W / 2;

  int unsigned w;
  logic [COMP_W-1:0] tr [NCOMP];

  assign w = depth_bits(depth, COMP_W);

  // Keep the top w bits of every component, right-aligned.
  for (genvar k = 0; k < NCOMP; k++) begin : g_trunc
    assign tr[k] = pix[k*COMP_W +: COMP_W] >> (COMP_W - w);
  end

  logic [PIX_W-1:0] y_ext, cb_ext, cr_ext, c_ext;
  assign y_ext  = {{(PIX_W-COMP_W){1'b0}}, tr[2]};
  assign cb_ext = {{(PIX_W-COMP_W){1'b0}}, tr[1]};
  assign cr_ext = {{(PIX_W-COMP_W){1'b0}}, tr[0]};
  assign c_ext  = odd ? cr_ext : cb_ext;

  always_comb begin
    rise = '0;
    fall = '0;
    unique case (fmt)
      FMT_SDR_444: rise = (y_ext << (2 * w)) | (cb_ext << w) | cr_ext;
      FMT_SDR_422: rise = (y_ext << w) | c_ext;
      FMT_DDR_422: begin
        rise = c_ext;
        fall = y_ext;
      end
      FMT_DDR_444: begin
        rise = {{(PIX_W-HALF_W){1'b0}}, pix[PIX_W-1:HALF_W]};
        fall = {{(PIX_W-HALF_W){1'b0}}, pix[HALF_W-1:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vfmt_sync.sv
module vfmt_sync (
  input  logic hs,
  input  logic vs,
  input  logic field,
  input  logic de,
  input  logic hs_pol,
  input  logic vs_pol,
  input  logic de_pol,
  input  logic vsel_field,
  output logic hs_out,
  output logic vsf_out,
  output logic de_out
);
  assign hs_out  = hs ^ hs_pol;
  assign vsf_out = (vsel_field ? field : vs) ^ vs_pol;
  assign de_out  = de ^ de_pol;
endmodule

// File: rtl/vfmt_top.sv
module vfmt_top #(
  parameter int COMP_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            fmt_i,
  input  logic [1:0]            depth_i,
  input  logic [3*COMP_W-1:0]   pix_i,
  input  logic                  hs_i,
  input  logic                  vs_i,
  input  logic                  field_i,
  input  logic                  de_i,
  input  logic                  hs_pol_i,
  input  logic                  vs_pol_i,
  input  logic                  de_pol_i,
  input  logic                  vsel_field_i,
  output logic [3*COMP_W-1:0]   rise_o,
  output logic [3*COMP_W-1:0]   fall_o,
  output logic                  hs_o,
  output logic                  vsf_o,
  output logic                  de_o
);
  import vfmt_pkg::*;

  localparam int PIX_W = 3 * COMP_W;

  // Named internal events used by the checker.
  logic chroma_odd;
  logic de_rise;

  vfmt_phase i_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .de_i      (de_i),
    .de_rise_o (de_rise),
    .odd_o     (chroma_odd)
  );

  // Stage 1: capture pixel, controls and timing.
  fmt_e             s1_fmt;
  logic [1:0]       s1_depth;
  logic             s1_odd;
  logic [PIX_W-1:0] s1_pix;
  logic             s1_hs, s1_vs, s1_field, s1_de;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_fmt   <= FMT_SDR_444;
      s1_depth <= '0;
      s1_odd   <= 1'b0;
      s1_pix   <= '0;
      s1_hs    <= 1'b0;
      s1_vs    <= 1'b0;
      s1_field <= 1'b0;
      s1_de    <= 1'b0;
    end else begin
      s1_fmt   <= fmt_e'(fmt_i);
      s1_depth <= depth_i;
      s1_odd   <= chroma_odd;
      s1_pix   <= pix_i;
      s1_hs    <= hs_i;
      s1_vs    <= vs_i;
      s1_field <= field_i;
      s1_de    <= de_i;
    end
  end

  logic [PIX_W-1:0] pk_rise, pk_fall;
  logic             sy_hs, sy_vsf, sy_de;

  vfmt_pack #(.COMP_W(COMP_W)) i_pack (
    .fmt   (s1_fmt),
    .depth (s1_depth),
    .odd   (s1_odd),
    .pix   (s1_pix),
    .rise  (pk_rise),
    .fall  (pk_fall)
  );

  vfmt_sync i_sync (
    .hs         (s1_hs),
    .vs         (s1_vs),
    .field      (s1_field),
    .de         (s1_de),
    .hs_pol     (hs_pol_i),
    .vs_pol     (vs_pol_i),
    .de_pol     (de_pol_i),
    .vsel_field (vsel_field_i),
    .hs_out     (sy_hs),
    .vsf_out    (sy_vsf),
    .de_out     (sy_de)
  );

  // Stage 2: output registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_o <= '0;
      fall_o <= '0;
      hs_o   <= 1'b0;
      vsf_o  <= 1'b0;
      de_o   <= 1'b0;
    end else begin
      rise_o <= pk_rise;
      fall_o <= pk_fall;
      hs_o   <= sy_hs;
      vsf_o  <= sy_vsf;
      de_o   <= sy_de;
    end
  end
endmodule

// File: rtl/vfmt_chk.sv
module vfmt_chk #(
  parameter int COMP_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          fmt_i,
  input logic [1:0]          depth_i,
  input logic [3*COMP_W-1:0] pix_i,
  input logic                hs_i,
  input logic                vs_i,
  input logic                field_i,
  input logic                de_i,
  input logic                hs_pol_i,
  input logic                vs_pol_i,
  input logic                de_pol_i,
  input logic                vsel_field_i,
  input logic [3*COMP_W-1:0] rise_o,
  input logic [3*COMP_W-1:0] fall_o,
  input logic                hs_o,
  input logic                vsf_o,
  input logic                de_o,
  input logic                chroma_odd
);
  localparam int PIX_W  = 3 * COMP_W;
  localparam int HALF_W = PIX_W / 2;

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  logic ok1, ok2;
  assign ok1 = age >= 2'd1;
  assign ok2 = age >= 2'd2;

  assert_de_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ok2 |-> de_o == ($past(de_i, 2) ^ $past(de_pol_i)));

  assert_hs_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ok2 |-> hs_o == ($past(hs_i, 2) ^ $past(hs_pol_i)));

  assert_vsf_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ok2 |-> vsf_o == (($past(vsel_field_i) ? $past(field_i, 2) : $past(vs_i, 2)) ^ $past(vs_pol_i)));

  assert_sdr_fall_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ok2 && $past(fmt_i, 2) <= 2'd1) |-> fall_o == '0);

  assert_sdr8_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ok2 && $past(fmt_i, 2) == 2'd0 && $past(depth_i, 2) == 2'd0) |-> rise_o[PIX_W-1:24] == '0);

  assert_ddr422_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ok2 && $past(fmt_i, 2) == 2'd2) |-> (rise_o[PIX_W-1:COMP_W] == '0 && fall_o[PIX_W-1:COMP_W] == '0));

  assert_ddr444_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ok2 && $past(fmt_i, 2) == 2'd3) |-> {rise_o[HALF_W-1:0], fall_o[HALF_W-1:0]} == $past(pix_i, 2));

  assert_phase_alternate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ok1 && de_i && $past(de_i)) |-> chroma_odd != $past(chroma_odd));

  assert_phase_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ok1 && $rose(de_i)) |-> !chroma_odd);
endmodule

bind vfmt_top vfmt_chk #(.COMP_W(COMP_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fmt_i        (fmt_i),
  .depth_i      (depth_i),
  .pix_i        (pix_i),
  .hs_i         (hs_i),
  .vs_i         (vs_i),
  .field_i      (field_i),
  .de_i         (de_i),
  .hs_pol_i     (hs_pol_i),
  .vs_pol_i     (vs_pol_i),
  .de_pol_i     (de_pol_i),
  .vsel_field_i (vsel_field_i),
  .rise_o       (rise_o),
  .fall_o       (fall_o),
  .hs_o         (hs_o),
  .vsf_o        (vsf_o),
  .de_o         (de_o),
  .chroma_odd   (chroma_odd)
);

// File: tb/test_vfmt_top.sv
module test_vfmt_top;
  localparam int COMP_W = 12;
  localparam int PIX_W  = 3 * COMP_W;
  localparam logic [PIX_W-1:0] PIX = 36'hABC123F5A;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [1:0] fmt, dep;
  logic [PIX_W-1:0] pix;
  logic hs, vs, field, de, hs_pol, vs_pol, de_pol, vsel;
  logic [PIX_W-1:0] rise, fall;
  logic hs_o, vsf_o, de_o;

  vfmt_top #(.COMP_W(COMP_W)) i_vfmt_top (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .depth_i(dep), .pix_i(pix),
    .hs_i(hs), .vs_i(vs), .field_i(field), .de_i(de),
    .hs_pol_i(hs_pol), .vs_pol_i(vs_pol), .de_pol_i(de_pol), .vsel_field_i(vsel),
    .rise_o(rise), .fall_o(fall), .hs_o(hs_o), .vsf_o(vsf_o), .de_o(de_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [2*PIX_W-1:0] act, input logic [2*PIX_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Stimulus: format, depth; expected {rise, fall} for an even then an odd pixel of PIX.
  typedef struct packed {
    logic [1:0]       f;
    logic [1:0]       d;
    logic [PIX_W-1:0] re;
    logic [PIX_W-1:0] fe;
    logic [PIX_W-1:0] ro;
    logic [PIX_W-1:0] fo;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd0, 36'h000AB12F5, 36'h0, 36'h000AB12F5, 36'h0},
    '{2'd0, 2'd1, 36'h02AF123D6, 36'h0, 36'h02AF123D6, 36'h0},
    '{2'd0, 2'd2, 36'hABC123F5A, 36'h0, 36'hABC123F5A, 36'h0},
    '{2'd1, 2'd0, 36'h00000AB12, 36'h0, 36'h00000ABF5, 36'h0},
    '{2'd1, 2'd1, 36'h0000ABC48, 36'h0, 36'h0000ABFD6, 36'h0},
    '{2'd1, 2'd2, 36'h000ABC123, 36'h0, 36'h000ABCF5A, 36'h0},
    '{2'd2, 2'd0, 36'h000000012, 36'h0000000AB, 36'h0000000F5, 36'h0000000AB},
    '{2'd2, 2'd1, 36'h000000048, 36'h0000002AF, 36'h0000003D6, 36'h0000002AF},
    '{2'd2, 2'd3, 36'h000000123, 36'h000000ABC, 36'h000000F5A, 36'h000000ABC},
    '{2'd3, 2'd0, 36'h00002AF04, 36'h000023F5A, 36'h00002AF04, 36'h000023F5A}
  };

  function automatic string req_of(input logic [1:0] f);
    case (f)
      2'd0: return "R3/R10";
      2'd1: return "R4/R5";
      2'd2: return "R6/R5";
      default: return "R7";
    endcase
  endfunction

  task automatic idle_inputs();
    pix = '0; hs = 1'b0; vs = 1'b0; field = 1'b0; de = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    fmt = 2'd0; dep = 2'd2; vsel = 1'b0;
    // R1: busy inputs and inverted polarity during reset.
    pix = PIX; hs = 1'b1; vs = 1'b1; field = 1'b1; de = 1'b1;
    hs_pol = 1'b1; vs_pol = 1'b1; de_pol = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "data during reset", {rise, fall}, '0);
    check("R1", "timing during reset", {69'b0, hs_o, vsf_o, de_o}, '0);
    idle_inputs();
    hs_pol = 1'b0; vs_pol = 1'b0; de_pol = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    check("R1", "data after reset", {rise, fall}, '0);

    // Table walk: even then odd pixel in each format and depth.
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      fmt = VECS[i].f; dep = VECS[i].d; idle_inputs();
      @(negedge clk) begin de = 1'b1; pix = PIX; end
      @(negedge clk);
      @(negedge clk);
      check(req_of(VECS[i].f), $sformatf("vec %0d even", i), {rise, fall}, {VECS[i].re, VECS[i].fe});
      idle_inputs();
      @(negedge clk);
      check(req_of(VECS[i].f), $sformatf("vec %0d odd", i), {rise, fall}, {VECS[i].ro, VECS[i].fo});
    end

    // R2: single pulse latency.
    @(negedge clk) begin fmt = 2'd0; dep = 2'd2; idle_inputs(); end
    @(negedge clk) begin de = 1'b1; hs = 1'b1; pix = PIX; end
    @(negedge clk) begin idle_inputs(); end
    check("R2", "de one clock in", {71'b0, de_o}, '0);
    @(negedge clk);
    check("R2", "two clocks: data hs de", {rise, 34'b0, hs_o, de_o}, {PIX, 34'b0, 1'b1, 1'b1});
    @(negedge clk);
    check("R2", "pulse ends", {71'b0, de_o}, '0);

    // R5: phase restart after a one-pixel burst.
    @(negedge clk) begin fmt = 2'd1; dep = 2'd2; idle_inputs(); end
    @(negedge clk) begin de = 1'b1; pix = PIX; end
    @(negedge clk) idle_inputs();
    @(negedge clk) begin
      check("R5", "lone pixel is even", {rise, fall}, {36'h000ABC123, 36'h0});
      de = 1'b1; pix = PIX;
    end
    @(negedge clk) idle_inputs();
    @(negedge clk) check("R5", "new burst restarts even", {rise, fall}, {36'h000ABC123, 36'h0});

    // R5: alternation over three pixels.
    @(negedge clk) begin de = 1'b1; pix = PIX; end
    @(negedge clk);
    @(negedge clk) check("R5", "pixel 0 Cb", {rise, fall}, {36'h000ABC123, 36'h0});
    @(negedge clk) begin
      check("R5", "pixel 1 Cr", {rise, fall}, {36'h000ABCF5A, 36'h0});
      idle_inputs();
    end
    @(negedge clk) check("R5", "pixel 2 Cb", {rise, fall}, {36'h000ABC123, 36'h0});

    // R8: inverted polarity with idle timing, then active timing.
    @(negedge clk) begin idle_inputs(); hs_pol = 1'b1; vs_pol = 1'b1; de_pol = 1'b1; end
    @(negedge clk);
    @(negedge clk) begin
      check("R8", "idle inverted", {69'b0, hs_o, vsf_o, de_o}, {69'b0, 3'b111});
      hs = 1'b1; vs = 1'b1; de = 1'b1;
    end
    @(negedge clk);
    @(negedge clk) check("R8", "active inverted", {69'b0, hs_o, vsf_o, de_o}, '0);
    @(negedge clk) begin idle_inputs(); hs_pol = 1'b0; vs_pol = 1'b0; de_pol = 1'b1; end
    @(negedge clk);
    @(negedge clk) check("R8", "only de inverted", {69'b0, hs_o, vsf_o, de_o}, {69'b0, 3'b001});

    // R9: vertical output source selection.
    @(negedge clk) begin de_pol = 1'b0; vsel = 1'b1; field = 1'b1; vs = 1'b0; end
    @(negedge clk);
    @(negedge clk) begin
      check("R9", "field selected", {71'b0, vsf_o}, {71'b0, 1'b1});
      vsel = 1'b0;
    end
    @(negedge clk);
    @(negedge clk) begin
      check("R9", "vsync selected, field ignored", {71'b0, vsf_o}, '0);
      vs = 1'b1; field = 1'b0;
    end
    @(negedge clk);
    @(negedge clk) check("R9", "vsync high", {71'b0, vsf_o}, {71'b0, 1'b1});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule